// File: doc/BRIEF.md
# Push-Button Event Status Register

This block sits on the input side of a small 8-bit soft processor. It collects presses from five buttons: Select, Right, Left, Up and Down. The presses arrive as clean, single-cycle pulses; debouncing and edge detection happen upstream. The block keeps them in one status byte that the processor can read through its port-mapped input path.

When a press arrives, the block does two things:
- It loads the button pattern into the low bits of the status byte.
- It sets a pending flag in the top bit. The pending flag also serves as the interrupt request.

The processor clears the pending flag in one of two ways: by reading the status byte with a read strobe whose port ID matches the block's address, or by acknowledging the interrupt. The button bits are not cleared. They keep the most recent press until a later press replaces them, so the processor can still see which button caused the event after the flag is gone.

The read-data output carries the status byte whenever the port ID matches the address, and zero otherwise. This lets it be OR-combined with other input sources. Reset is asynchronous and active low. It is released through a short synchronizer inside the block.

Top module: `btn_event_reg`

## Requirements
- R1: While reset is applied, and after it is released with no press yet, irq is 0 and a read at the block's address returns 8'h00.
- R2: A cycle with any bit of btn_pulse high sets the pending flag (bit 7) and loads btn_pulse into bits 4:0 on that clock edge. The bit positions are 4 Select, 3 Right, 2 Left, 1 Up, 0 Down.
- R3: Bits 6 and 5 of rd_data always read 0.
- R4: irq equals the pending flag, which is bit 7 of the status byte.
- R5: A cycle with rd_strobe high and port_id equal to PORT_ADDR clears the pending flag at that clock edge, and leaves bits 4:0 unchanged.
- R6: A cycle with irq_ack high clears the pending flag at that clock edge, and leaves bits 4:0 unchanged.
- R7: If a press occurs in the same cycle as a clear (read or acknowledge), the press wins. The flag stays 1 and bits 4:0 take the new pattern.
- R8: A read strobe whose port_id differs from PORT_ADDR does not change the pending flag.
- R9: rd_data is 8'h00 whenever port_id differs from PORT_ADDR, and is the status byte whenever it matches, whether or not rd_strobe is high.
- R10: In a cycle with no press, bits 4:0 keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| btn_pulse | input | 5 | One-cycle press pulses: [4] Select, [3] Right, [2] Left, [1] Up, [0] Down |
| rd_strobe | input | 1 | Processor input strobe |
| port_id | input | 8 | Processor port address |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request; equals the pending flag |
| rd_data | output | 8 | Status byte when port_id matches, otherwise zero |

## Verification
A corrupted pending flag shows up on irq in the same cycle, and on bit 7 of rd_data as soon as the port ID selects the block. Corrupted button bits show up on the next read at the block's address. The bench therefore compares both outputs against its model every cycle, with the matching port ID applied for most of the run. The hardest cases are those where a clear and a press arrive together, and where a read strobe targets a different address. The bench drives both of these directly, and also inside a long pseudo-random stretch.

// File: rtl/btncap_pkg.sv
package btncap_pkg;
  localparam int unsigned BTN_W    = 5;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned FLAG_POS = DATA_W - 1;

  typedef logic [BTN_W-1:0]  btn_vec_t;
  typedef logic [DATA_W-1:0] byte_t;

  function automatic byte_t pack_status(input logic flag, input btn_vec_t bits);
    byte_t r;
    r = '0;
    r[FLAG_POS]  = flag;
    r[BTN_W-1:0] = bits;
    return r;
  endfunction
endpackage

// File: rtl/btncap_rst_sync.sv
module btncap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/btncap_latch.sv
module btncap_latch
  import btncap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  btn_vec_t btn_pulse,
  output logic     press,
  output btn_vec_t bits_q
);
  logic     load_en;
  btn_vec_t bits_d;

  always_comb begin
    load_en = |btn_pulse;
    bits_d  = btn_pulse;
    press   = load_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits_q <= '0;
    else if (load_en) bits_q <= bits_d;
  end
endmodule

// File: rtl/btncap_flag.sv
module btncap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic press,
  input  logic clr_rd,
  input  logic clr_ack,
  output logic flag_q
);
  logic flag_d;
  logic upd_en;

  always_comb begin
    upd_en = press | clr_rd | clr_ack;
    flag_d = press;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (upd_en) flag_q <= flag_d;
  end
endmodule

// File: rtl/btncap_rdmux.sv
module btncap_rdmux
  import btncap_pkg::*;
#(
  parameter int unsigned ID_W      = 8,
  parameter logic [ID_W-1:0] PORT_ADDR = '0
) (
  input  logic [ID_W-1:0] port_id,
  input  logic            flag,
  input  btn_vec_t        bits,
  output logic            sel_hit,
  output byte_t           rd_data
);
  always_comb begin
    sel_hit = (port_id == PORT_ADDR);
    rd_data = sel_hit ? pack_status(flag, bits) : '0;
  end
endmodule

// File: rtl/btn_event_reg.sv
module btn_event_reg
  import btncap_pkg::*;
#(
  parameter int unsigned ID_W        = 8,
  parameter logic [ID_W-1:0] PORT_ADDR = 8'h0A,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BTN_W-1:0]  btn_pulse,
  input  logic              rd_strobe,
  input  logic [ID_W-1:0]   port_id,
  input  logic              irq_ack,
  output logic              irq,
  output logic [DATA_W-1:0] rd_data
);
  logic     rst_core_n;
  logic     press;
  logic     sel_hit;
  logic     clr_rd;
  logic     flag_q;
  btn_vec_t bits_q;

  btncap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_core_n)
  );

  btncap_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .btn_pulse (btn_pulse),
    .press     (press),
    .bits_q    (bits_q)
  );

  always_comb begin
    clr_rd = rd_strobe & sel_hit;
  end

  btncap_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .press   (press),
    .clr_rd  (clr_rd),
    .clr_ack (irq_ack),
    .flag_q  (flag_q)
  );

  btncap_rdmux #(.ID_W(ID_W), .PORT_ADDR(PORT_ADDR)) u_rdmux (
    .port_id (port_id),
    .flag    (flag_q),
    .bits    (bits_q),
    .sel_hit (sel_hit),
    .rd_data (rd_data)
  );

  assign irq = flag_q;
endmodule

// File: rtl/btn_event_reg_chk.sv
module btn_event_reg_chk
  import btncap_pkg::*;
#(
  parameter int unsigned ID_W = 8,
  parameter logic [ID_W-1:0] PORT_ADDR = 8'h0A
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BTN_W-1:0]  btn_pulse,
  input logic              rd_strobe,
  input logic [ID_W-1:0]   port_id,
  input logic              irq_ack,
  input logic              irq,
  input logic [DATA_W-1:0] rd_data,
  input logic [BTN_W-1:0]  bits_q
);
  AST_PRESS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|btn_pulse) |=> (irq && bits_q == $past(btn_pulse))); // R2
  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:5] == 2'b00); // R3
  AST_IRQ_MIRRORS: assert property (@(posedge clk) disable iff (!rst_n)
    (port_id == PORT_ADDR) |-> (rd_data[7] == irq)); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && port_id == PORT_ADDR && !(|btn_pulse)) |=> !irq); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(|btn_pulse)) |=> !irq); // R6
  AST_PRESS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|btn_pulse) && (irq_ack || (rd_strobe && port_id == PORT_ADDR))) |=> irq); // R7
  AST_OTHER_PORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack && !(rd_strobe && port_id == PORT_ADDR)) |=> irq); // R8
  AST_NOMATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (port_id != PORT_ADDR) |-> (rd_data == '0)); // R9
  AST_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(|btn_pulse) |=> $stable(bits_q)); // R10
endmodule

bind btn_event_reg btn_event_reg_chk #(.ID_W(ID_W), .PORT_ADDR(PORT_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .btn_pulse (btn_pulse),
  .rd_strobe (rd_strobe),
  .port_id   (port_id),
  .irq_ack   (irq_ack),
  .irq       (irq),
  .rd_data   (rd_data),
  .bits_q    (bits_q)
);

// File: tb/btn_event_reg_bench.sv
module btn_event_reg_bench;
  localparam logic [7:0] ADDR = 8'h0A;
  localparam logic [7:0] OTHER = 8'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] btn_pulse = '0;
  logic       rd_strobe = 1'b0;
  logic [7:0] port_id = ADDR;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_flag = 0;
  int m_bits = 0;

  always #4 clk = ~clk;

  btn_event_reg u_btn_event_reg (
    .clk(clk), .rst_n(rst_n), .btn_pulse(btn_pulse), .rd_strobe(rd_strobe),
    .port_id(port_id), .irq_ack(irq_ack), .irq(irq), .rd_data(rd_data)
  );

  task automatic compare(input string tag);
    int exp_rd;
    exp_rd = (port_id == ADDR) ? ((m_flag << 7) | m_bits) : 0;
    checks++;
    if (irq !== m_flag[0]) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, m_flag[0]);
    end
    checks++;
    if (rd_data !== exp_rd[7:0]) begin
      errors++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", tag, rd_data, exp_rd[7:0]);
    end
  endtask

  task automatic step(input logic [4:0] b, input logic rd, input logic [7:0] pid,
                      input logic ack, input string tag);
    @(negedge clk);
    btn_pulse = b; rd_strobe = rd; port_id = pid; irq_ack = ack;
    #1 compare(tag);
    @(posedge clk);
    if (b != 0) begin
      m_flag = 1; m_bits = b;
    end else if (ack || (rd && pid == ADDR)) begin
      m_flag = 0;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) step(5'b00000, 1'b0, ADDR, 1'b0, "R1");
    rst_n = 1'b1;
    repeat (4) step(5'b00000, 1'b0, ADDR, 1'b0, "R1");
    // single presses on each position, each read back and cleared
    for (int i = 0; i < 5; i++) begin
      step(5'b00001 << i, 1'b0, ADDR, 1'b0, "R2");
      step(5'b00000, 1'b0, ADDR, 1'b0, "R3");
      step(5'b00000, 1'b1, ADDR, 1'b0, "R5");
      step(5'b00000, 1'b0, ADDR, 1'b0, "R10");
    end
    // acknowledge clears flag, bits kept
    step(5'b10100, 1'b0, ADDR, 1'b0, "R2");
    step(5'b00000, 1'b0, ADDR, 1'b1, "R6");
    step(5'b00000, 1'b0, ADDR, 1'b0, "R4");
    // read to another port does nothing; output zero there
    step(5'b01011, 1'b0, ADDR, 1'b0, "R2");
    step(5'b00000, 1'b1, OTHER, 1'b0, "R8");
    step(5'b00000, 1'b0, OTHER, 1'b0, "R9");
    step(5'b00000, 1'b0, ADDR, 1'b0, "R8");
    step(5'b00000, 1'b0, ADDR, 1'b0, "R9");
    // press collides with clears
    step(5'b00010, 1'b1, ADDR, 1'b0, "R7");
    step(5'b00000, 1'b0, ADDR, 1'b0, "R7");
    step(5'b10000, 1'b0, ADDR, 1'b1, "R7");
    step(5'b00000, 1'b0, ADDR, 1'b0, "R7");
    step(5'b00100, 1'b1, ADDR, 1'b1, "R7");
    step(5'b00000, 1'b1, ADDR, 1'b1, "R5");
    step(5'b00000, 1'b0, ADDR, 1'b0, "R10");
    // pseudo-random stretch
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      logic [4:0] b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = (lfsr[2:0] == 3'd0) ? lfsr[8:4] : 5'b00000;
      step(b, lfsr[9] & lfsr[3], (lfsr[11:10] == 2'd0) ? OTHER : ADDR,
           lfsr[14] & lfsr[12], "R7");
    end
    // asynchronous reset mid-run
    step(5'b11111, 1'b0, ADDR, 1'b0, "R2");
    @(negedge clk);
    rst_n = 1'b0;
    m_flag = 0; m_bits = 0;
    #1 compare("R1");
    rst_n = 1'b1;
    repeat (3) step(5'b00000, 1'b0, ADDR, 1'b0, "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule